// File: doc/BRIEF.md
# Burst-Mode AMI Loop Framer (master end)

This block is the master-end framer for one two-wire loop that carries traffic in both directions by taking turns (time-compression multiplexing). On every second frame-sync pulse it captures B1, B2 and D data from two 8 kHz frames as one parallel word. It then sends a burst of ternary AMI symbols on a symbol-rate clock enable. The burst begins with an unscrambled start mark. The 36 payload bits follow, passed through a self-synchronising x^9+x^5+1 scrambler. The line then stays quiet for a fixed guard interval, after which the far end may answer.

While the transmitter sits waiting between bursts, the receive side listens for the reply. It treats the first mark it hears as the reply's start bit and descrambles the 36 symbols after it. It returns the two frames of B1, B2 and D as parallel fields with a one-clock valid strobe. It also pulses a violation flag whenever two successive received marks have the same polarity.

Transmit states: TX_OFF (line inactive), TX_WAIT (quiet, receiver open), TX_START (start mark), TX_DATA (payload), TX_GUARD (quiet guard). Transitions are taken on symbol ticks:
- TX_OFF to TX_WAIT when the line is active.
- TX_WAIT to TX_START on a burst sync.
- TX_START to TX_DATA always.
- TX_DATA to TX_GUARD after the last payload symbol.
- TX_GUARD to TX_WAIT after the last guard symbol.
- Any state to TX_OFF when the line is inactive.

Receive states: RX_OFF, RX_HUNT (waiting for a start mark), RX_DATA (collecting payload). Transitions are taken on symbol ticks:
- RX_OFF to RX_HUNT when the line is active.
- RX_HUNT to RX_DATA on a mark while the receiver is open.
- RX_DATA to RX_HUNT after the last payload symbol, or when the transmitter leaves TX_WAIT.
- Any state to RX_OFF when the line is inactive.

Top module: `tcm_ami_framer`

## Requirements
- R1: After reset, and at every symbol tick while `line_act` is low, `tx_code` is 00 and no burst is sent; `rx_valid` stays low out of reset.
- R2: `tx_code` only takes the values 00 (no pulse), 01 (positive pulse) and 10 (negative pulse). It changes only in the clock after a cycle with `sym_en` high.
- R3: Sync pulses on `fs` are counted from activation. The first pulse, and every second one after it, starts a burst. A burst is a start mark, then 36 payload symbols, then 6 zero symbols of guard. The other pulses send nothing.
- R4: The start symbol is always a mark that is not scrambled. Its polarity is opposite to the last mark sent, and the first start after activation is positive (01).
- R5: Payload order is frame 0 then frame 1. Each frame is B1 as 8 bits MSB first, then B2 as 8 bits MSB first, then D as 2 bits MSB first. Frame f is taken from index f of `tx_b1`, `tx_b2` and `tx_d`.
- R6: Each payload bit d is sent as s = d xor s(n-5) xor s(n-9), where s(n-k) is the scrambled bit sent k payload bits earlier. Scrambler history starts as all ones and carries over from burst to burst. Start bits are not part of the history.
- R7: A scrambled one is sent as a mark of the opposite polarity to the previous mark; a scrambled zero is sent as 00.
- R8: When `tx_en_b1`, `tx_en_b2` or `tx_en_d` is low, that channel's bits are replaced by ones before scrambling in both frames.
- R9: The receiver listens only while the transmitter waits between bursts. It takes the first mark as a start bit and descrambles the next 36 symbols with the same polynomial. It then pulses `rx_valid` for one clock, with the fields in the order of R5.
- R10: `rx_viol` pulses for one clock when a received mark has the same polarity as the previous received mark; alternating marks never raise it.
- R11: Deactivation resets scrambler and descrambler history to all ones and both polarity trackers, so the first start after reactivation is positive and the scrambler starts again from all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_en | input | 1 | Symbol-rate clock enable |
| fs | input | 1 | Frame sync pulse, held until the next symbol tick |
| line_act | input | 1 | Line activated when high |
| tx_en_b1 | input | 1 | Transmit B1 enable (low sends ones) |
| tx_en_b2 | input | 1 | Transmit B2 enable (low sends ones) |
| tx_en_d | input | 1 | Transmit D enable (low sends ones) |
| tx_b1 | input | N_FRM x B_W | B1 octet per frame |
| tx_b2 | input | N_FRM x B_W | B2 octet per frame |
| tx_d | input | N_FRM x D_W | D bits per frame |
| tx_code | output | 2 | Line symbol: 00 zero, 01 positive, 10 negative |
| rx_code | input | 2 | Received line symbol, same coding |
| rx_b1 | output | N_FRM x B_W | Received B1 per frame |
| rx_b2 | output | N_FRM x B_W | Received B2 per frame |
| rx_d | output | N_FRM x D_W | Received D per frame |
| rx_valid | output | 1 | One-clock strobe: received fields updated |
| rx_viol | output | 1 | One-clock strobe: AMI polarity violation |

## Verification
On every cycle the assertions check the legal symbol coding and the hold of `tx_code` between ticks. They check that marks alternate in polarity across bursts and that the line is silent once deactivated. They also check that the receive strobes are single-clock pulses tied to a tick. Scrambler continuity across bursts, the every-second-sync burst rule, payload order, channel masking and the descrambled round trip need the bench's scenarios. The same holds for violation detection and the restart after reactivation. There the expected symbol stream comes from a separate model and recorded bursts are played back into the receiver.

// File: rtl/tcm_ami_pkg.sv
package tcm_ami_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_POS  = 2'b01,
        SYM_NEG  = 2'b10
    } sym_t;

    typedef enum logic [2:0] {
        TX_OFF,
        TX_WAIT,
        TX_START,
        TX_DATA,
        TX_GUARD
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_OFF,
        RX_HUNT,
        RX_DATA
    } rx_state_t;

    // Mark polarity that follows a mark of the given sign.
    function automatic sym_t mark_after(input logic last_was_neg);
        return last_was_neg ? SYM_POS : SYM_NEG;
    endfunction

endpackage

// File: rtl/tcm_scrambler.sv
module tcm_scrambler #(
    parameter int LEN        = 9,
    parameter int TAP        = 5,
    parameter bit DESCRAMBLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic din,
    output logic dout
);

    logic [LEN-1:0] hist_q;
    logic           shift_in;

    assign dout = din ^ hist_q[TAP-1] ^ hist_q[LEN-1];

    // History holds line-side bits in both variants.
    generate
        if (DESCRAMBLE) begin : g_descr
            assign shift_in = din;
        end else begin : g_scr
            assign shift_in = dout;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else if (clr) begin
            hist_q <= '1;
        end else if (step) begin
            hist_q <= {hist_q[LEN-2:0], shift_in};
        end
    end

endmodule

// File: rtl/tcm_tx_framer.sv
module tcm_tx_framer
    import tcm_ami_pkg::*;
#(
    parameter int PW      = 36,
    parameter int GUARD   = 6,
    parameter int SCR_LEN = 9,
    parameter int SCR_TAP = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sym_en,
    input  logic          fs,
    input  logic          act,
    input  logic [PW-1:0] payload,
    output logic [1:0]    line_code,
    output logic          listen
);

    localparam int CMAX = (PW > GUARD) ? PW : GUARD;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] LAST_DATA  = CW'(PW - 1);
    localparam logic [CW-1:0] LAST_GUARD = CW'(GUARD - 1);

    tx_state_t     st_q, st_d;
    logic          fs_pend_q;
    logic          phase_q;
    logic          fs_hit;
    logic          burst_req;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] sh_q;
    logic          last_neg_q;
    sym_t          code_q;
    logic          scr_out;
    logic          scr_step;
    logic          scr_clr;

    assign fs_hit    = sym_en & (fs | fs_pend_q);
    assign burst_req = fs_hit & ~phase_q;
    assign scr_step  = sym_en & act & (st_q == TX_DATA);
    assign scr_clr   = sym_en & ~act;

    tcm_scrambler #(
        .LEN        (SCR_LEN),
        .TAP        (SCR_TAP),
        .DESCRAMBLE (1'b0)
    ) i_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (scr_clr),
        .step  (scr_step),
        .din   (sh_q[PW-1]),
        .dout  (scr_out)
    );

    // Sync pulse held until the next symbol tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_pend_q <= 1'b0;
        end else if (sym_en) begin
            fs_pend_q <= 1'b0;
        end else if (fs) begin
            fs_pend_q <= 1'b1;
        end
    end

    // Every second sync starts a burst, counted from activation.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (sym_en) begin
            if (!act || st_q == TX_OFF) begin
                phase_q <= 1'b0;
            end else if (fs_hit) begin
                phase_q <= ~phase_q;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (!act) begin
            st_d = TX_OFF;
        end else begin
            unique case (st_q)
                TX_OFF:   st_d = TX_WAIT;
                TX_WAIT:  if (burst_req) st_d = TX_START;
                TX_START: st_d = TX_DATA;
                TX_DATA:  if (cnt_q == LAST_DATA) st_d = TX_GUARD;
                TX_GUARD: if (cnt_q == LAST_GUARD) st_d = TX_WAIT;
                default:  st_d = TX_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TX_OFF;
        end else if (sym_en) begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q     <= SYM_ZERO;
            last_neg_q <= 1'b1;
            cnt_q      <= '0;
            sh_q       <= '0;
        end else if (sym_en) begin
            if (!act) begin
                code_q     <= SYM_ZERO;
                last_neg_q <= 1'b1;
                cnt_q      <= '0;
            end else begin
                unique case (st_q)
                    TX_OFF: begin
                        code_q <= SYM_ZERO;
                        cnt_q  <= '0;
                    end
                    TX_WAIT: begin
                        code_q <= SYM_ZERO;
                        cnt_q  <= '0;
                        if (burst_req) sh_q <= payload;
                    end
                    TX_START: begin
                        code_q     <= mark_after(last_neg_q);
                        last_neg_q <= ~last_neg_q;
                        cnt_q      <= '0;
                    end
                    TX_DATA: begin
                        sh_q <= {sh_q[PW-2:0], 1'b0};
                        if (scr_out) begin
                            code_q     <= mark_after(last_neg_q);
                            last_neg_q <= ~last_neg_q;
                        end else begin
                            code_q <= SYM_ZERO;
                        end
                        cnt_q <= (cnt_q == LAST_DATA) ? '0 : cnt_q + 1'b1;
                    end
                    TX_GUARD: begin
                        code_q <= SYM_ZERO;
                        cnt_q  <= cnt_q + 1'b1;
                    end
                    default: begin
                        code_q <= SYM_ZERO;
                        cnt_q  <= '0;
                    end
                endcase
            end
        end
    end

    assign line_code = code_q;
    assign listen    = (st_q == TX_WAIT);

endmodule

// File: rtl/tcm_rx_deframer.sv
module tcm_rx_deframer
    import tcm_ami_pkg::*;
#(
    parameter int PW      = 36,
    parameter int SCR_LEN = 9,
    parameter int SCR_TAP = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sym_en,
    input  logic          act,
    input  logic          listen,
    input  logic [1:0]    rx_code,
    output logic [PW-1:0] payload,
    output logic          valid,
    output logic          viol
);

    localparam int CW = $clog2(PW + 1);
    localparam logic [CW-1:0] LAST_DATA = CW'(PW - 1);

    rx_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] sh_q;
    logic [PW-1:0] pay_q;
    logic          last_neg_q;
    logic          valid_q;
    logic          viol_q;
    logic          is_mark;
    logic          is_neg;
    logic          heard;
    logic          dscr_out;
    logic          dscr_step;
    logic          dscr_clr;

    assign is_neg    = (rx_code == SYM_NEG);
    assign is_mark   = (rx_code == SYM_POS) || is_neg;
    assign heard     = sym_en & act & listen & (st_q != RX_OFF);
    assign dscr_step = heard & (st_q == RX_DATA);
    assign dscr_clr  = sym_en & ~act;

    tcm_scrambler #(
        .LEN        (SCR_LEN),
        .TAP        (SCR_TAP),
        .DESCRAMBLE (1'b1)
    ) i_dscr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dscr_clr),
        .step  (dscr_step),
        .din   (is_mark),
        .dout  (dscr_out)
    );

    always_comb begin
        st_d = st_q;
        if (!act) begin
            st_d = RX_OFF;
        end else begin
            unique case (st_q)
                RX_OFF:  st_d = RX_HUNT;
                RX_HUNT: if (listen && is_mark) st_d = RX_DATA;
                RX_DATA: begin
                    if (!listen || cnt_q == LAST_DATA) st_d = RX_HUNT;
                end
                default: st_d = RX_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RX_OFF;
        end else if (sym_en) begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sh_q       <= '0;
            pay_q      <= '0;
            last_neg_q <= 1'b1;
            valid_q    <= 1'b0;
            viol_q     <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            viol_q  <= 1'b0;
            if (sym_en) begin
                if (!act) begin
                    last_neg_q <= 1'b1;
                    cnt_q      <= '0;
                end else begin
                    if (heard && is_mark) begin
                        viol_q     <= (is_neg == last_neg_q);
                        last_neg_q <= is_neg;
                    end
                    unique case (st_q)
                        RX_DATA: begin
                            if (listen) begin
                                sh_q <= {sh_q[PW-2:0], dscr_out};
                                if (cnt_q == LAST_DATA) begin
                                    pay_q   <= {sh_q[PW-2:0], dscr_out};
                                    valid_q <= 1'b1;
                                    cnt_q   <= '0;
                                end else begin
                                    cnt_q <= cnt_q + 1'b1;
                                end
                            end else begin
                                cnt_q <= '0;
                            end
                        end
                        default: cnt_q <= '0;
                    endcase
                end
            end
        end
    end

    assign payload = pay_q;
    assign valid   = valid_q;
    assign viol    = viol_q;

endmodule

// File: rtl/tcm_ami_framer.sv
module tcm_ami_framer
    import tcm_ami_pkg::*;
#(
    parameter int B_W        = 8,
    parameter int D_W        = 2,
    parameter int N_FRM      = 2,
    parameter int GUARD_SYMS = 6,
    parameter int SCR_LEN    = 9,
    parameter int SCR_TAP    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sym_en,
    input  logic                      fs,
    input  logic                      line_act,
    input  logic                      tx_en_b1,
    input  logic                      tx_en_b2,
    input  logic                      tx_en_d,
    input  logic [N_FRM-1:0][B_W-1:0] tx_b1,
    input  logic [N_FRM-1:0][B_W-1:0] tx_b2,
    input  logic [N_FRM-1:0][D_W-1:0] tx_d,
    output logic [1:0]                tx_code,
    input  logic [1:0]                rx_code,
    output logic [N_FRM-1:0][B_W-1:0] rx_b1,
    output logic [N_FRM-1:0][B_W-1:0] rx_b2,
    output logic [N_FRM-1:0][D_W-1:0] rx_d,
    output logic                      rx_valid,
    output logic                      rx_viol
);

    localparam int GW = 2 * B_W + D_W;
    localparam int PW = N_FRM * GW;

    logic [PW-1:0] tx_payload;
    logic [PW-1:0] rx_payload;
    logic          rx_open;

    // Frame 0 occupies the most significant group, sent first.
    generate
        for (genvar f = 0; f < N_FRM; f++) begin : g_frm
            localparam int HI = PW - 1 - f * GW;
            assign tx_payload[HI -: GW] = {
                tx_en_b1 ? tx_b1[f] : {B_W{1'b1}},
                tx_en_b2 ? tx_b2[f] : {B_W{1'b1}},
                tx_en_d  ? tx_d[f]  : {D_W{1'b1}}
            };
            assign rx_b1[f] = rx_payload[HI -: B_W];
            assign rx_b2[f] = rx_payload[HI - B_W -: B_W];
            assign rx_d[f]  = rx_payload[HI - 2 * B_W -: D_W];
        end
    endgenerate

    tcm_tx_framer #(
        .PW      (PW),
        .GUARD   (GUARD_SYMS),
        .SCR_LEN (SCR_LEN),
        .SCR_TAP (SCR_TAP)
    ) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_en    (sym_en),
        .fs        (fs),
        .act       (line_act),
        .payload   (tx_payload),
        .line_code (tx_code),
        .listen    (rx_open)
    );

    tcm_rx_deframer #(
        .PW      (PW),
        .SCR_LEN (SCR_LEN),
        .SCR_TAP (SCR_TAP)
    ) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym_en  (sym_en),
        .act     (line_act),
        .listen  (rx_open),
        .rx_code (rx_code),
        .payload (rx_payload),
        .valid   (rx_valid),
        .viol    (rx_viol)
    );

endmodule

// File: rtl/tcm_ami_framer_chk.sv
module tcm_ami_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_en,
    input logic       line_act,
    input logic [1:0] tx_code,
    input logic       rx_valid,
    input logic       rx_viol
);

    logic tick_d;
    logic last_pos;
    logic is_mark;

    assign is_mark = (tx_code == 2'b01) || (tx_code == 2'b10);

    // Polarity of the last mark seen on the line pins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_d   <= 1'b0;
            last_pos <= 1'b0;
        end else begin
            tick_d <= sym_en;
            if (sym_en && !line_act) begin
                last_pos <= 1'b0;
            end else if (tick_d && is_mark) begin
                last_pos <= (tx_code == 2'b01);
            end
        end
    end

    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        tx_code != 2'b11);

    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_en |=> $stable(tx_code));

    a_r7_marks_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_d && is_mark) |-> ((tx_code == 2'b01) != last_pos));

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_en && !line_act) |=> (tx_code == 2'b00));

    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r9_valid_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sym_en));

    a_r10_viol_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rx_viol |-> $past(sym_en));

endmodule

bind tcm_ami_framer tcm_ami_framer_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_en   (sym_en),
    .line_act (line_act),
    .tx_code  (tx_code),
    .rx_valid (rx_valid),
    .rx_viol  (rx_viol)
);

// File: tb/test_tcm_ami_framer.sv
`timescale 1ns/1ps
module test_tcm_ami_framer;

    localparam logic [1:0] C_Z = 2'b00;
    localparam logic [1:0] C_P = 2'b01;
    localparam logic [1:0] C_N = 2'b10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sym_en = 1'b0;
    logic             fs = 1'b0;
    logic             line_act = 1'b0;
    logic             tx_en_b1 = 1'b1;
    logic             tx_en_b2 = 1'b1;
    logic             tx_en_d = 1'b1;
    logic [1:0][7:0]  tx_b1 = '0;
    logic [1:0][7:0]  tx_b2 = '0;
    logic [1:0][1:0]  tx_d = '0;
    logic [1:0]       tx_code;
    logic [1:0]       rx_code = 2'b00;
    logic [1:0][7:0]  rx_b1;
    logic [1:0][7:0]  rx_b2;
    logic [1:0][1:0]  rx_d;
    logic             rx_valid;
    logic             rx_viol;

    always #2.5 clk = ~clk;

    tcm_ami_framer i_tcm_ami_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_en   (sym_en),
        .fs       (fs),
        .line_act (line_act),
        .tx_en_b1 (tx_en_b1),
        .tx_en_b2 (tx_en_b2),
        .tx_en_d  (tx_en_d),
        .tx_b1    (tx_b1),
        .tx_b2    (tx_b2),
        .tx_d     (tx_d),
        .tx_code  (tx_code),
        .rx_code  (rx_code),
        .rx_b1    (rx_b1),
        .rx_b2    (rx_b2),
        .rx_d     (rx_d),
        .rx_valid (rx_valid),
        .rx_viol  (rx_viol)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [1:0]  expq[$];
    logic [1:0]  rxq[$];
    logic [1:0]  rec[$];
    logic [35:0] rx_expq[$];
    int          rx_skip = 0;
    int          viol_seen = 0;
    bit          started = 1'b0;
    int          pos = 0;
    int          tick_phase = 0;
    logic [8:0]  m_scr = '1;
    bit          m_neg = 1'b1;

    task automatic check(input bit ok, input string req, input logic [63:0] act_v, input logic [63:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    function automatic logic [35:0] rx_word();
        return {rx_b1[0], rx_b2[0], rx_d[0], rx_b1[1], rx_b2[1], rx_d[1]};
    endfunction

    // Monitor and symbol-enable generator: sym_en is read before it changes.
    always @(negedge clk) begin
        logic [1:0]  e;
        logic [35:0] ew;
        if (rst_n && sym_en) begin
            if (expq.size() > 0 && (started || tx_code != C_Z)) begin
                e = expq.pop_front();
                started = 1'b1;
                if (pos < 37) rec.push_back(tx_code);
                pos++;
                check(tx_code == e, "R4 R5 R6 R7 burst symbol", 64'(tx_code), 64'(e));
                if (expq.size() == 0) begin
                    started = 1'b0;
                    pos = 0;
                end
            end else if (expq.size() == 0) begin
                check(tx_code == C_Z, "R3 line quiet outside burst", 64'(tx_code), 64'(C_Z));
            end
            rx_code = (rxq.size() > 0) ? rxq.pop_front() : C_Z;
        end
        if (rx_valid) begin
            if (rx_skip > 0) begin
                rx_skip--;
            end else if (rx_expq.size() > 0) begin
                ew = rx_expq.pop_front();
                check(rx_word() == ew, "R9 received fields", 64'(rx_word()), 64'(ew));
            end else begin
                check(1'b0, "R9 unexpected rx_valid", 64'(1), 64'(0));
            end
        end
        if (rx_viol) viol_seen++;
        tick_phase = (tick_phase + 1) % 4;
        sym_en = (tick_phase == 0);
    end

    task automatic ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic pulse_fs();
        @(negedge clk);
        fs = 1'b1;
        @(negedge clk);
        fs = 1'b0;
    endtask

    // Expected payload after masking, order per R5 and R8.
    function automatic logic [35:0] masked();
        logic [7:0] m1 [2];
        logic [7:0] m2 [2];
        logic [1:0] md [2];
        for (int f = 0; f < 2; f++) begin
            m1[f] = tx_en_b1 ? tx_b1[f] : 8'hFF;
            m2[f] = tx_en_b2 ? tx_b2[f] : 8'hFF;
            md[f] = tx_en_d  ? tx_d[f]  : 2'b11;
        end
        return {m1[0], m2[0], md[0], m1[1], m2[1], md[1]};
    endfunction

    // Driver: expected line symbols from the R4, R6 and R7 rules.
    task automatic push_burst(input logic [35:0] p);
        logic sb;
        expq.push_back(m_neg ? C_P : C_N);
        m_neg = ~m_neg;
        for (int i = 35; i >= 0; i--) begin
            sb = p[i] ^ m_scr[4] ^ m_scr[8];
            m_scr = {m_scr[7:0], sb};
            if (sb) begin
                expq.push_back(m_neg ? C_P : C_N);
                m_neg = ~m_neg;
            end else begin
                expq.push_back(C_Z);
            end
        end
        for (int i = 0; i < 6; i++) expq.push_back(C_Z);
    endtask

    task automatic send_and_replay();
        logic [35:0] p;
        p = masked();
        rec.delete();
        push_burst(p);
        pulse_fs();
        ticks(50);
        check(expq.size() == 0, "R3 burst of start, 36 payload, 6 guard", 64'(expq.size()), 64'(0));
        rx_expq.push_back(p);
        foreach (rec[i]) rxq.push_back(rec[i]);
        ticks(45);
        check(rx_expq.size() == 0, "R9 reply decoded", 64'(rx_expq.size()), 64'(0));
    endtask

    initial begin
        logic [1:0] lastm;
        repeat (5) @(negedge clk);
        check(tx_code == C_Z, "R1 tx_code after reset", 64'(tx_code), 64'(C_Z));
        check(rx_valid == 1'b0, "R1 rx_valid after reset", 64'(rx_valid), 64'(0));
        rst_n = 1'b1;
        ticks(10);
        // R1: sync while inactive sends nothing.
        pulse_fs();
        ticks(20);
        check(tx_code == C_Z, "R1 inactive line quiet", 64'(tx_code), 64'(C_Z));

        line_act = 1'b1;
        ticks(3);
        tx_b1 = {8'h3C, 8'hA5};
        tx_b2 = {8'h81, 8'h5A};
        tx_d  = {2'b01, 2'b10};
        send_and_replay();
        // R3: second sync of the pair sends nothing.
        pulse_fs();
        ticks(50);

        tx_b1 = '0; tx_b2 = '0; tx_d = '0;
        send_and_replay();
        pulse_fs();
        ticks(50);

        // R8: B2 and D disabled.
        tx_b1 = {8'hF0, 8'h0F};
        tx_b2 = {8'h12, 8'h34};
        tx_d  = {2'b00, 2'b00};
        tx_en_b2 = 1'b0;
        tx_en_d  = 1'b0;
        send_and_replay();
        tx_en_b2 = 1'b1;
        tx_en_d  = 1'b1;
        pulse_fs();
        ticks(50);
        check(viol_seen == 0, "R10 no violation on alternating marks", 64'(viol_seen), 64'(0));

        // R10: start mark with the same polarity as the previous mark.
        lastm = C_Z;
        foreach (rec[i]) if (rec[i] != C_Z) lastm = rec[i];
        rx_skip = 1;
        rxq.push_back(lastm);
        for (int i = 0; i < 36; i++) rxq.push_back(C_Z);
        ticks(45);
        check(viol_seen == 1, "R10 repeated polarity flagged", 64'(viol_seen), 64'(1));

        // R11: deactivate, then restart from reset history.
        line_act = 1'b0;
        ticks(5);
        m_scr = '1;
        m_neg = 1'b1;
        pulse_fs();
        ticks(10);
        check(tx_code == C_Z, "R11 deactivated line quiet", 64'(tx_code), 64'(C_Z));
        line_act = 1'b1;
        ticks(3);
        tx_b1 = {8'h77, 8'hC3};
        tx_b2 = {8'h00, 8'hFF};
        tx_d  = {2'b11, 2'b01};
        send_and_replay();
        check(rec.size() > 0 && rec[0] == C_P, "R11 first start positive", 64'(rec[0]), 64'(C_P));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule